// File: doc/BRIEF.md
# Victim Invalidation Queue

This block sits beside a snoop filter in a coherent home node. When the filter is full and a lookup misses, the filter must evict one of its tracked lines. The filter entry is dropped at once, but the caching agents that may still hold that line have not yet been invalidated. This queue remembers the victim line address for that window. The window starts when the filter is updated and ends when the invalidation of the requesting caches completes.

The queue has four ports. An allocate port accepts victim addresses. A search port is compared against every live entry in parallel. A hit on the search port tells the snoop logic to ignore the filter's precise sharer vector and send a multicast snoop. This ensures that no cache still holding a silently evicted line is missed. If an address misses both the filter and this queue, the line is absent from every requesting cache.

An issue port offers pending entries to the transaction tracker as back-invalidation requests, in allocation order. A retire port frees an entry by index once its invalidation is done. When every slot is occupied, the queue withholds `alloc_ready`, and the filter cannot evict again until a slot retires.

Top module: `victim_inval_queue`

## Requirements
- R1: After reset, no entry is live: `alloc_ready` is 1, `issue_valid` is 0 and `search_hit` is 0 for any address.
- R2: When `alloc_valid` and `alloc_ready` are both 1 at a clock edge, the address is stored in the lowest-numbered free slot. That slot number is later shown on `issue_idx`, with the address on `issue_addr`.
- R3: `search_hit` is 1 in the same cycle if and only if some live entry, issued or not, holds exactly `search_addr`. An entry becomes visible on the cycle after it is allocated, and it stays visible until it retires.
- R4: `alloc_ready` is 0 exactly when all DEPTH slots are live. An `alloc_valid` seen while `alloc_ready` is 0 stores nothing.
- R5: `issue_valid` is 1 whenever an allocated entry has not yet been issued. The entry presented is the oldest such entry by allocation order. A handshake (`issue_valid` and `issue_ready` both 1) marks it issued, and the next entry is offered from the following cycle. There is no bypass: an entry is offered no earlier than the cycle after its allocation.
- R6: `retire_valid` with `retire_idx` naming a live, issued slot frees that slot at the clock edge. From the next cycle its address no longer hits.
- R7: A retire that names a free slot, or a slot not yet issued, is ignored. The entry stays live and is still offered or searchable as before.
- R8: A slot freed by a retire raises `alloc_ready` on the next cycle if the queue was full. The slot can be reallocated from then on.
- R9: Allocation, issue handshake and retire in the same cycle act independently. Each takes effect at the same edge, and each is judged on the state before that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| alloc_valid | input | 1 | Victim address offered for storage |
| alloc_addr | input | ADDR_W | Victim line address |
| alloc_ready | output | 1 | A free slot exists |
| search_addr | input | ADDR_W | Line address of a snoop-needing request |
| search_hit | output | 1 | Address is pending invalidation; snoop must be multicast |
| issue_valid | output | 1 | An unissued entry is offered |
| issue_idx | output | IDX_W | Slot of the offered entry |
| issue_addr | output | ADDR_W | Address of the offered entry |
| issue_ready | input | 1 | Tracker takes the offered entry |
| retire_valid | input | 1 | Invalidation of a slot has completed |
| retire_idx | input | IDX_W | Slot to free |

## Verification
Some properties are checked on every cycle by the assertions:
- an offered entry is always live and unissued;
- the issued flags stay a subset of the live flags;
- a refused allocation never raises occupancy;
- a retire frees its slot only when that slot was issued;
- a hit implies some entry is live.

Other behaviour only the scenarios can show: the exact address matching, the lowest-free-slot choice, allocation-order issue across slot reuse, and the cycle on which a retire makes room for the next victim. A behavioural model in the bench follows all of these on every clock, under directed phases and a mixed random phase.

// File: rtl/viq_pkg.sv
package viq_pkg;
  localparam int unsigned VIQ_DEF_DEPTH  = 8;
  localparam int unsigned VIQ_DEF_ADDR_W = 40;

  typedef struct packed {
    logic live;
    logic sent;
  } viq_flags_t;
endpackage

// File: rtl/viq_free_pick.sv
module viq_free_pick #(
  parameter int unsigned DEPTH = 8,
  parameter int unsigned IDX_W = 3
) (
  input  logic [DEPTH-1:0] live,
  output logic             any_free,
  output logic [IDX_W-1:0] free_idx
);
  always_comb begin
    any_free = 1'b0;
    free_idx = '0;
    for (int i = DEPTH - 1; i >= 0; i--) begin
      if (!live[i]) begin
        any_free = 1'b1;
        free_idx = IDX_W'(i);
      end
    end
  end
endmodule

// File: rtl/viq_cam.sv
module viq_cam #(
  parameter int unsigned DEPTH  = 8,
  parameter int unsigned ADDR_W = 40
) (
  input  logic [DEPTH-1:0]             live,
  input  logic [DEPTH-1:0][ADDR_W-1:0] tags,
  input  logic [ADDR_W-1:0]            key,
  output logic                         hit
);
  logic [DEPTH-1:0] match;

  for (genvar g = 0; g < DEPTH; g++) begin : g_cmp
    assign match[g] = live[g] && (tags[g] == key);
  end

  assign hit = |match;
endmodule

// File: rtl/viq_order_fifo.sv
module viq_order_fifo #(
  parameter int unsigned DEPTH = 8,
  parameter int unsigned IDX_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push,
  input  logic [IDX_W-1:0] push_idx,
  input  logic             pop,
  output logic             head_valid,
  output logic [IDX_W-1:0] head_idx
);
  localparam logic [IDX_W-1:0] LAST = IDX_W'(DEPTH - 1);

  logic [IDX_W-1:0] ring_q [DEPTH];
  logic [IDX_W-1:0] rd_q, rd_d, wr_q, wr_d;
  logic [IDX_W:0]   cnt_q, cnt_d;
  logic             do_pop;

  assign head_valid = (cnt_q != '0);
  assign head_idx   = ring_q[rd_q];
  assign do_pop     = pop && head_valid;

  always_comb begin
    rd_d  = rd_q;
    wr_d  = wr_q;
    cnt_d = cnt_q;
    if (do_pop) begin
      rd_d = (rd_q == LAST) ? '0 : rd_q + 1'b1;
    end
    if (push) begin
      wr_d = (wr_q == LAST) ? '0 : wr_q + 1'b1;
    end
    if (push && !do_pop) begin
      cnt_d = cnt_q + 1'b1;
    end else if (do_pop && !push) begin
      cnt_d = cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_q  <= '0;
      wr_q  <= '0;
      cnt_q <= '0;
    end else begin
      rd_q  <= rd_d;
      wr_q  <= wr_d;
      cnt_q <= cnt_d;
    end
  end

  always_ff @(posedge clk) begin
    if (push) begin
      ring_q[wr_q] <= push_idx;
    end
  end
endmodule

// File: rtl/victim_inval_queue.sv
module victim_inval_queue
  import viq_pkg::*;
#(
  parameter int unsigned DEPTH  = VIQ_DEF_DEPTH,
  parameter int unsigned ADDR_W = VIQ_DEF_ADDR_W,
  parameter int unsigned IDX_W  = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              alloc_valid,
  input  logic [ADDR_W-1:0] alloc_addr,
  output logic              alloc_ready,
  input  logic [ADDR_W-1:0] search_addr,
  output logic              search_hit,
  output logic              issue_valid,
  output logic [IDX_W-1:0]  issue_idx,
  output logic [ADDR_W-1:0] issue_addr,
  input  logic              issue_ready,
  input  logic              retire_valid,
  input  logic [IDX_W-1:0]  retire_idx
);
  localparam logic [IDX_W:0] DEPTH_LIM = (IDX_W + 1)'(DEPTH);

  viq_flags_t [DEPTH-1:0]      flag_q, flag_d;
  logic [DEPTH-1:0]            valid_q, issued_q;
  logic [DEPTH-1:0][ADDR_W-1:0] addr_q;
  logic                        any_free;
  logic [IDX_W-1:0]            free_idx;
  logic                        alloc_fire, issue_fire, retire_ok;
  logic                        head_valid;
  logic [IDX_W-1:0]            head_idx;

  for (genvar g = 0; g < DEPTH; g++) begin : g_unpack
    assign valid_q[g]  = flag_q[g].live;
    assign issued_q[g] = flag_q[g].sent;
  end

  viq_free_pick #(.DEPTH(DEPTH), .IDX_W(IDX_W)) u_pick (
    .live     (valid_q),
    .any_free (any_free),
    .free_idx (free_idx)
  );

  viq_cam #(.DEPTH(DEPTH), .ADDR_W(ADDR_W)) u_cam (
    .live (valid_q),
    .tags (addr_q),
    .key  (search_addr),
    .hit  (search_hit)
  );

  viq_order_fifo #(.DEPTH(DEPTH), .IDX_W(IDX_W)) u_order (
    .clk        (clk),
    .rst_n      (rst_n),
    .push       (alloc_fire),
    .push_idx   (free_idx),
    .pop        (issue_fire),
    .head_valid (head_valid),
    .head_idx   (head_idx)
  );

  assign alloc_ready = any_free;
  assign alloc_fire  = alloc_valid && any_free;
  assign issue_valid = head_valid;
  assign issue_idx   = head_idx;
  assign issue_addr  = addr_q[head_idx];
  assign issue_fire  = head_valid && issue_ready;
  assign retire_ok   = retire_valid && ({1'b0, retire_idx} < DEPTH_LIM) &&
                       valid_q[retire_idx] && issued_q[retire_idx];

  always_comb begin
    flag_d = flag_q;
    if (retire_ok) begin
      flag_d[retire_idx] = '{live: 1'b0, sent: 1'b0};
    end
    if (issue_fire) begin
      flag_d[head_idx].sent = 1'b1;
    end
    if (alloc_fire) begin
      flag_d[free_idx] = '{live: 1'b1, sent: 1'b0};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_q <= '0;
    end else begin
      flag_q <= flag_d;
    end
  end

  always_ff @(posedge clk) begin
    if (alloc_fire) begin
      addr_q[free_idx] <= alloc_addr;
    end
  end
endmodule

// File: rtl/viq_checker.sv
module viq_checker #(
  parameter int unsigned DEPTH = 8,
  parameter int unsigned IDX_W = 3
) (
  input logic             clk,
  input logic             rst_n,
  input logic             alloc_ready,
  input logic             search_hit,
  input logic             issue_valid,
  input logic [IDX_W-1:0] issue_idx,
  input logic             retire_valid,
  input logic [IDX_W-1:0] retire_idx,
  input logic [DEPTH-1:0] valid_q,
  input logic [DEPTH-1:0] issued_q
);
  AST_ISSUE_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
    issue_valid |-> (valid_q[issue_idx] && !issued_q[issue_idx])); // R5

  AST_SENT_SUBSET: assert property (@(posedge clk) disable iff (!rst_n)
    (issued_q & ~valid_q) == '0); // R6

  AST_FULL_NO_GROWTH: assert property (@(posedge clk) disable iff (!rst_n)
    !alloc_ready |=> ($countones(valid_q) <= $past($countones(valid_q)))); // R4

  AST_RETIRE_FREES: assert property (@(posedge clk) disable iff (!rst_n)
    (retire_valid && valid_q[retire_idx] && issued_q[retire_idx])
      |=> !valid_q[$past(retire_idx)]); // R6

  AST_RETIRE_UNSENT_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
    (retire_valid && valid_q[retire_idx] && !issued_q[retire_idx])
      |=> valid_q[$past(retire_idx)]); // R7

  AST_HIT_NEEDS_LIVE: assert property (@(posedge clk) disable iff (!rst_n)
    search_hit |-> (valid_q != '0)); // R3
endmodule

bind victim_inval_queue viq_checker #(.DEPTH(DEPTH), .IDX_W(IDX_W)) u_viq_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .alloc_ready  (alloc_ready),
  .search_hit   (search_hit),
  .issue_valid  (issue_valid),
  .issue_idx    (issue_idx),
  .retire_valid (retire_valid),
  .retire_idx   (retire_idx),
  .valid_q      (valid_q),
  .issued_q     (issued_q)
);

// File: tb/victim_inval_queue_tb.sv
module victim_inval_queue_tb;
  localparam int CLK_PERIOD = 10;
  localparam int DEPTH  = 8;
  localparam int ADDR_W = 40;
  localparam int IDX_W  = 3;

  logic              clk = 1'b0;
  logic              rst_n;
  logic              alloc_valid;
  logic [ADDR_W-1:0] alloc_addr;
  logic              alloc_ready;
  logic [ADDR_W-1:0] search_addr;
  logic              search_hit;
  logic              issue_valid;
  logic [IDX_W-1:0]  issue_idx;
  logic [ADDR_W-1:0] issue_addr;
  logic              issue_ready;
  logic              retire_valid;
  logic [IDX_W-1:0]  retire_idx;

  int n_cmp = 0;
  int n_bad = 0;
  string phase = "R1";

  bit [ADDR_W-1:0] m_addr [DEPTH];
  bit              m_live [DEPTH];
  bit              m_sent [DEPTH];
  int              m_order [$];

  always #(CLK_PERIOD / 2) clk = ~clk;

  victim_inval_queue #(.DEPTH(DEPTH), .ADDR_W(ADDR_W)) u_dut (
    .clk(clk), .rst_n(rst_n),
    .alloc_valid(alloc_valid), .alloc_addr(alloc_addr), .alloc_ready(alloc_ready),
    .search_addr(search_addr), .search_hit(search_hit),
    .issue_valid(issue_valid), .issue_idx(issue_idx), .issue_addr(issue_addr),
    .issue_ready(issue_ready),
    .retire_valid(retire_valid), .retire_idx(retire_idx)
  );

  task automatic cmp(string what, logic [63:0] act, logic [63:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FIL%s %s %s: actual %0h expected %0h", "", phase, what, act, exp);
    end
  endtask

  function automatic int first_free();
    for (int i = 0; i < DEPTH; i++) if (!m_live[i]) return i;
    return -1;
  endfunction

  function automatic bit model_hit(bit [ADDR_W-1:0] a);
    for (int i = 0; i < DEPTH; i++) if (m_live[i] && m_addr[i] == a) return 1'b1;
    return 1'b0;
  endfunction

  // One cycle: inputs are applied after a falling edge, outputs compared, model advanced.
  task automatic step(bit av, bit [ADDR_W-1:0] aa, bit ir, bit rv, int ri,
                      bit [ADDR_W-1:0] sa);
    int  slot;
    bit  e_ready, e_iv, ret_ok;
    alloc_valid  = av;
    alloc_addr   = aa;
    issue_ready  = ir;
    retire_valid = rv;
    retire_idx   = IDX_W'(ri);
    search_addr  = sa;
    #1;
    slot    = first_free();
    e_ready = (slot >= 0);
    e_iv    = (m_order.size() > 0);
    cmp("alloc_ready (R4 full flag)", 64'(alloc_ready), 64'(e_ready));
    cmp("search_hit (R3 match)", 64'(search_hit), 64'(model_hit(sa)));
    cmp("issue_valid (R5 pending)", 64'(issue_valid), 64'(e_iv));
    if (e_iv) begin
      cmp("issue_idx (R2/R5 slot order)", 64'(issue_idx), 64'(m_order[0]));
      cmp("issue_addr (R5 address)", 64'(issue_addr), 64'(m_addr[m_order[0]]));
    end
    ret_ok = rv && m_live[ri] && m_sent[ri];
    if (ret_ok) begin
      m_live[ri] = 1'b0;
      m_sent[ri] = 1'b0;
    end
    if (e_iv && ir) begin
      m_sent[m_order[0]] = 1'b1;
      void'(m_order.pop_front());
    end
    if (av && e_ready) begin
      m_live[slot] = 1'b1;
      m_sent[slot] = 1'b0;
      m_addr[slot] = aa;
      m_order.push_back(slot);
    end
    @(posedge clk);
    @(negedge clk);
  endtask

  function automatic bit [ADDR_W-1:0] va(int k);
    return {8'hA5, 32'(k * 64 + 32'h1000)};
  endfunction

  task automatic finish_run();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_cmp++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    for (int i = 0; i < DEPTH; i++) begin
      m_live[i] = 0; m_sent[i] = 0; m_addr[i] = '0;
    end
    rst_n = 1'b0;
    alloc_valid = 0; alloc_addr = '0; issue_ready = 0;
    retire_valid = 0; retire_idx = '0; search_addr = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;

    // R1: empty after reset
    phase = "R1";
    step(0, '0, 0, 0, 0, va(0));
    step(0, '0, 1, 1, 0, va(1));

    // R2: three allocations fill slots 0,1,2; R3 hits next cycle, not same cycle
    phase = "R2";
    step(1, va(10), 0, 0, 0, va(10));
    step(1, va(11), 0, 0, 0, va(10));
    step(1, va(12), 0, 0, 0, va(11));
    phase = "R3";
    step(0, '0, 0, 0, 0, va(12));
    step(0, '0, 0, 0, 0, va(13));

    // R7: retire of unissued slot 0 and of free slot 5 ignored
    phase = "R7";
    step(0, '0, 0, 1, 0, va(10));
    step(0, '0, 0, 1, 5, va(10));
    step(0, '0, 0, 0, 0, va(10));

    // R5: issue in allocation order
    phase = "R5";
    step(0, '0, 1, 0, 0, va(10));
    step(0, '0, 1, 0, 0, va(11));
    step(0, '0, 0, 0, 0, va(11));

    // R6: retire issued slot 1, then its address misses
    phase = "R6";
    step(0, '0, 0, 1, 1, va(11));
    step(0, '0, 0, 0, 0, va(11));
    step(0, '0, 0, 1, 0, va(10));
    step(0, '0, 0, 0, 0, va(10));

    // R2: freed slot 0 reused before higher slots
    phase = "R2";
    step(1, va(20), 0, 0, 0, va(20));
    step(0, '0, 0, 0, 0, va(20));

    // R4: fill to full, refused allocation leaves no trace
    phase = "R4";
    for (int k = 0; k < DEPTH; k++) step(1, va(30 + k), 0, 0, 0, va(30));
    step(1, va(99), 0, 0, 0, va(99));
    step(0, '0, 0, 0, 0, va(99));

    // R8: issue head, retire it, room appears next cycle and is reused
    phase = "R8";
    step(0, '0, 1, 0, 0, va(20));
    step(0, '0, 0, 1, 2, va(12));
    step(1, va(50), 0, 0, 0, va(50));
    step(0, '0, 0, 0, 0, va(50));

    // R9: allocation, issue and retire mixed freely in the same cycles
    phase = "R9";
    for (int c = 0; c < 400; c++) begin
      int r;
      int pick;
      r = int'($urandom_range(0, 255));
      pick = int'($urandom_range(0, DEPTH - 1));
      step(r[0] | r[1], va(60 + c % 23), r[2], r[3] | r[4], pick,
           r[5] ? va(60 + int'($urandom_range(0, 22))) : m_addr[pick]);
    end
    // drain
    for (int c = 0; c < 40; c++) step(0, '0, 1, 1, c % DEPTH, va(60 + c % 23));

    finish_run();
  end
endmodule